// File: doc/BRIEF.md
# Flag-Driven Adaptive Routing Table

This block holds one routing entry per destination node inside a mesh router. Each entry is a four-bit port vector, one bit for each output direction (North, East, South, West). While the network rebuilds its routes after a link failure, a one-bit flag travels outward from each node in turn. Every cycle the router reports which of its input ports saw that flag and which node is currently sending it. The table records those ports under the sender's entry. Only the first non-empty arrival for a destination is kept, so only shortest paths are recorded. When flags arrive on several ports in the same cycle, all of them are stored together, which gives the router a choice of routes later.

During normal operation, route computation presents a destination and the number of free virtual channels behind each output port. One cycle later the table returns the chosen port and a valid bit. The chosen port is the recorded port with the most free channels. A lookup of the node's own ID returns local ejection. A destination whose entry is still empty is reported as unreachable. While recovery is in progress every lookup returns invalid, so head flits hold until the new table is complete.

Top module: `flag_route_table`

## Requirements
- R1: After reset every entry is empty and `route_ok_o` is 0.
- R2: When `recovering_i` is 1, `inval_i` is 0, `flag_mask_i` is non-zero, `bcast_id_i` differs from `self_id_i` and entry `bcast_id_i` is empty, the entry takes the value of `flag_mask_i` at the clock edge. Bit 0 stands for North, bit 1 for East, bit 2 for South and bit 3 for West, and several bits can be stored at once.
- R3: Once an entry is non-empty, later flag writes to it are ignored until the next invalidate.
- R4: Flag writes are ignored while `recovering_i` is 0, and are also ignored when `bcast_id_i` equals `self_id_i`.
- R5: When `inval_i` is 1, every entry is cleared at the clock edge. This takes priority over a flag write in the same cycle.
- R6: When `recovering_i` is 0 and the destination's entry is non-empty, the next cycle shows `route_ok_o`=1 and an `out_port_o` naming the recorded port with the largest free-VC count. Port codes are N=0, E=1, S=2, W=3. Ties go to the lowest code. The count for port p is `free_vc_i[p*VC_W +: VC_W]`.
- R7: When `recovering_i` is 0 and the destination is not `self_id_i` and its entry is empty, the next cycle shows `route_ok_o`=0 (unreachable).
- R8: When `recovering_i` is 0 and the destination equals `self_id_i`, the next cycle shows `route_ok_o`=1 and `out_port_o`=4 (local ejection).
- R9: When `recovering_i` is 1, the next cycle shows `route_ok_o`=0, whatever the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_id_i | input | ID_W | ID of this node (held static) |
| recovering_i | input | 1 | Reconfiguration in progress |
| inval_i | input | 1 | Clear every entry |
| bcast_id_i | input | ID_W | ID of the node whose flag is currently spreading |
| flag_mask_i | input | 4 | Ports that received the flag this cycle |
| lkp_dst_i | input | ID_W | Destination to look up |
| free_vc_i | input | 4*VC_W | Free virtual-channel count per output port |
| route_ok_o | output | 1 | Lookup result valid (0 = recovering or unreachable) |
| out_port_o | output | 3 | Chosen port: 0 N, 1 E, 2 S, 3 W, 4 local |

## Verification
The directed cases cover several situations:
- a multi-bit first write followed by a conflicting second write, which separates a locking entry from one that ORs or overwrites;
- a write from the node's own ID, and a write while not recovering;
- an invalidate that coincides with a write, which shows whether the clear takes priority;
- lookups with one leading free-VC count and with tied counts, which separate the max-select from a fixed-priority choice and show that the tie-break works.

Seeded random rounds then mix invalidates, random sender IDs, and sparse random masks that often set several bits. These are interleaved with lookups carrying random VC counts, both during and after recovery. This exercises locking against many arrival orders and exercises the selection rule against every mask shape.

// File: rtl/frt_pkg.sv
package frt_pkg;

    localparam int NUM_PORTS = 4;

    typedef enum logic [2:0] {
        PORT_N     = 3'd0,
        PORT_E     = 3'd1,
        PORT_S     = 3'd2,
        PORT_W     = 3'd3,
        PORT_LOCAL = 3'd4
    } port_e;

    typedef struct packed {
        logic  ok;
        port_e port;
    } lkp_res_t;

endpackage

// File: rtl/frt_entry_store.sv
module frt_entry_store
    import frt_pkg::*;
#(
    parameter int NUM_NODES = 16,
    parameter int ID_W      = $clog2(NUM_NODES)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [ID_W-1:0]                      self_id_i,
    input  logic                                 recovering_i,
    input  logic                                 inval_i,
    input  logic [ID_W-1:0]                      bcast_id_i,
    input  logic [NUM_PORTS-1:0]                 flag_mask_i,
    output logic [NUM_NODES-1:0][NUM_PORTS-1:0]  entries_o
);

    typedef struct packed {
        logic [NUM_NODES-1:0][NUM_PORTS-1:0] ent;
    } store_t;

    store_t st_d, st_q;
    logic   wr_allowed;
    logic   tgt_empty;

    always_comb begin
        st_d       = st_q;
        tgt_empty  = (st_q.ent[bcast_id_i] == '0);
        wr_allowed = recovering_i && (flag_mask_i != '0)
                     && (bcast_id_i != self_id_i) && tgt_empty;
        if (inval_i) begin
            st_d.ent = '0;
        end else if (wr_allowed) begin
            st_d.ent[bcast_id_i] = st_q.ent[bcast_id_i] | flag_mask_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign entries_o = st_q.ent;

endmodule

// File: rtl/frt_port_pick.sv
module frt_port_pick
    import frt_pkg::*;
#(
    parameter int VC_W = 3
) (
    input  logic [NUM_PORTS-1:0]      cand_i,
    input  logic [NUM_PORTS*VC_W-1:0] free_vc_i,
    output logic                      any_o,
    output logic [1:0]                idx_o
);

    logic [VC_W-1:0] cnt [NUM_PORTS];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_slice
        assign cnt[p] = free_vc_i[p*VC_W +: VC_W];
    end

    logic [VC_W-1:0] best_cnt;

    always_comb begin
        any_o    = 1'b0;
        idx_o    = 2'd0;
        best_cnt = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (cand_i[p] && (!any_o || (cnt[p] > best_cnt))) begin
                any_o    = 1'b1;
                idx_o    = 2'(p);
                best_cnt = cnt[p];
            end
        end
    end

endmodule

// File: rtl/flag_route_table.sv
module flag_route_table
    import frt_pkg::*;
#(
    parameter int NUM_NODES = 16,
    parameter int VC_W      = 3,
    parameter int ID_W      = $clog2(NUM_NODES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ID_W-1:0]           self_id_i,
    input  logic                      recovering_i,
    input  logic                      inval_i,
    input  logic [ID_W-1:0]           bcast_id_i,
    input  logic [3:0]                flag_mask_i,
    input  logic [ID_W-1:0]           lkp_dst_i,
    input  logic [4*VC_W-1:0]         free_vc_i,
    output logic                      route_ok_o,
    output logic [2:0]                out_port_o
);

    logic [NUM_NODES-1:0][NUM_PORTS-1:0] tbl_q;
    logic [NUM_PORTS-1:0]                dst_entry;
    logic                                pick_any;
    logic [1:0]                          pick_idx;
    lkp_res_t                            res_d, res_q;

    frt_entry_store #(
        .NUM_NODES (NUM_NODES),
        .ID_W      (ID_W)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .self_id_i    (self_id_i),
        .recovering_i (recovering_i),
        .inval_i      (inval_i),
        .bcast_id_i   (bcast_id_i),
        .flag_mask_i  (flag_mask_i),
        .entries_o    (tbl_q)
    );

    assign dst_entry = tbl_q[lkp_dst_i];

    frt_port_pick #(
        .VC_W (VC_W)
    ) u_pick (
        .cand_i    (dst_entry),
        .free_vc_i (free_vc_i),
        .any_o     (pick_any),
        .idx_o     (pick_idx)
    );

    always_comb begin
        res_d.ok   = 1'b0;
        res_d.port = PORT_N;
        if (!recovering_i) begin
            if (lkp_dst_i == self_id_i) begin
                res_d.ok   = 1'b1;
                res_d.port = PORT_LOCAL;
            end else if (pick_any) begin
                res_d.ok   = 1'b1;
                res_d.port = port_e'({1'b0, pick_idx});
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '{ok: 1'b0, port: PORT_N};
        end else begin
            res_q <= res_d;
        end
    end

    assign route_ok_o = res_q.ok;
    assign out_port_o = res_q.port;

endmodule

// File: rtl/frt_checker.sv
module frt_checker #(
    parameter int NUM_NODES = 16,
    parameter int ID_W      = $clog2(NUM_NODES)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ID_W-1:0]        self_id_i,
    input logic                   recovering_i,
    input logic                   inval_i,
    input logic [ID_W-1:0]        bcast_id_i,
    input logic [ID_W-1:0]        lkp_dst_i,
    input logic                   route_ok_o,
    input logic [2:0]             out_port_o,
    input logic [NUM_NODES*4-1:0] tbl
);

    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> (tbl == '0) && !route_ok_o);                               // R1

    AST_ENTRY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!inval_i && (tbl[{bcast_id_i, 2'b00} +: 4] != 4'd0)) |=> $stable(tbl)); // R3

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!recovering_i && !inval_i) |=> $stable(tbl));                        // R4

    AST_SELF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tbl[{self_id_i, 2'b00} +: 4] == 4'd0);                                // R4

    AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        inval_i |=> tbl == '0);                                               // R5

    AST_PORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        route_ok_o |-> out_port_o <= 3'd4);                                   // R6

    AST_SELF_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!recovering_i && (lkp_dst_i == self_id_i)) |=> route_ok_o && (out_port_o == 3'd4)); // R8

    AST_RECOV_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        recovering_i |=> !route_ok_o);                                        // R9

endmodule

bind flag_route_table frt_checker #(
    .NUM_NODES (NUM_NODES),
    .ID_W      (ID_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .self_id_i    (self_id_i),
    .recovering_i (recovering_i),
    .inval_i      (inval_i),
    .bcast_id_i   (bcast_id_i),
    .lkp_dst_i    (lkp_dst_i),
    .route_ok_o   (route_ok_o),
    .out_port_o   (out_port_o),
    .tbl          (tbl_q)
);

// File: tb/flag_route_table_tb.sv
module flag_route_table_tb;

    localparam int NN   = 16;
    localparam int IDW  = 4;
    localparam int VCW  = 3;
    localparam logic [IDW-1:0] SELF = 4'd9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             recovering = 1'b0;
    logic             inval = 1'b0;
    logic [IDW-1:0]   bcast = '0;
    logic [3:0]       mask = '0;
    logic [IDW-1:0]   dst = '0;
    logic [4*VCW-1:0] vcs = '0;
    logic             route_ok;
    logic [2:0]       out_port;

    int checks = 0;
    int errors = 0;
    logic [3:0] mdl [NN];

    always #4 clk = ~clk;

    flag_route_table #(.NUM_NODES(NN), .VC_W(VCW)) u_dut (
        .clk(clk), .rst_n(rst_n), .self_id_i(SELF),
        .recovering_i(recovering), .inval_i(inval),
        .bcast_id_i(bcast), .flag_mask_i(mask),
        .lkp_dst_i(dst), .free_vc_i(vcs),
        .route_ok_o(route_ok), .out_port_o(out_port)
    );

    function automatic logic [2:0] exp_pick(input logic [3:0] m, input logic [4*VCW-1:0] v);
        logic [2:0] best = 3'd0;
        int bc = -1;
        for (int p = 0; p < 4; p++) begin
            if (m[p] && int'(v[p*VCW +: VCW]) > bc) begin
                bc   = int'(v[p*VCW +: VCW]);
                best = 3'(p);
            end
        end
        return best;
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Apply current inputs for one edge, update the model and compare.
    task automatic step(input string tag_in);
        logic       e_ok;
        logic [2:0] e_port;
        string      tag;
        e_ok   = 1'b0;
        e_port = 3'd0;
        if (recovering)         tag = "R9";
        else if (dst == SELF)   begin tag = "R8"; e_ok = 1'b1; e_port = 3'd4; end
        else if (mdl[dst] == 0) tag = "R7";
        else begin tag = "R6"; e_ok = 1'b1; e_port = exp_pick(mdl[dst], vcs); end
        if (tag_in != "") tag = tag_in;
        if (inval) begin
            for (int i = 0; i < NN; i++) mdl[i] = 4'd0;
        end else if (recovering && mask != 0 && bcast != SELF && mdl[bcast] == 0) begin
            mdl[bcast] = mask;
        end
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (route_ok !== e_ok || (e_ok && out_port !== e_port)) begin
            errors++;
            $display("FAIL %s: dst=%0d ok=%0d port=%0d expected ok=%0d port=%0d",
                     tag, dst, route_ok, out_port, e_ok, e_port);
        end
    endtask

    task automatic set_in(input logic r, input logic iv, input logic [IDW-1:0] b,
                          input logic [3:0] m, input logic [IDW-1:0] d,
                          input logic [4*VCW-1:0] v);
        recovering = r; inval = iv; bcast = b; mask = m; dst = d; vcs = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: ok=%0d port=%0d expected completion", route_ok, out_port);
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < NN; i++) mdl[i] = 4'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (route_ok !== 1'b0) begin
            errors++;
            $display("FAIL R1: ok=%0d expected ok=0", route_ok);
        end
        rst_n = 1'b1;
        // R1: empty table after reset
        for (int d = 0; d < NN; d++) begin
            set_in(1'b0, 1'b0, 4'd0, 4'd0, 4'(d), '0);
            step(d == int'(SELF) ? "R8" : "R1");
        end

        // Directed recovery sequence
        set_in(1'b1, 1'b1, 4'd0, 4'd0, 4'd3, '0); step("R9");
        set_in(1'b1, 1'b0, 4'd3, 4'b0101, 4'd3, '0); step("R2");
        set_in(1'b1, 1'b0, 4'd3, 4'b0010, 4'd3, '0); step("R3");
        set_in(1'b1, 1'b0, SELF, 4'b1111, 4'd3, '0); step("R4");
        set_in(1'b1, 1'b0, 4'd5, 4'b1000, 4'd3, '0); step("R2");
        set_in(1'b1, 1'b1, 4'd6, 4'b1000, 4'd3, '0); step("R5");
        set_in(1'b1, 1'b0, 4'd3, 4'b0101, 4'd3, '0); step("R2");
        set_in(1'b0, 1'b0, 4'd7, 4'b0001, 4'd3, {3'd0, 3'd5, 3'd0, 3'd2}); step("R6");
        set_in(1'b0, 1'b0, 4'd0, 4'd0, 4'd3, {3'd0, 3'd4, 3'd0, 3'd4}); step("R6");
        set_in(1'b0, 1'b0, 4'd0, 4'd0, 4'd3, {3'd7, 3'd1, 3'd7, 3'd2}); step("R6");
        set_in(1'b0, 1'b0, 4'd0, 4'd0, 4'd7, '0); step("R4");
        set_in(1'b0, 1'b0, 4'd0, 4'd0, 4'd5, '0); step("R5");
        set_in(1'b0, 1'b0, 4'd0, 4'd0, 4'd6, '0); step("R5");
        set_in(1'b0, 1'b0, 4'd0, 4'd0, SELF, '0); step("R8");
        set_in(1'b0, 1'b0, 4'd0, 4'd0, SELF, '0); step("R8");
        set_in(1'b0, 1'b0, 4'd0, 4'd0, 4'd3, '0); step("R6");

        // Seeded random rounds
        for (int r = 0; r < 4; r++) begin
            set_in(1'b1, 1'b1, 4'd0, 4'd0, 4'd0, '0); step("R5");
            for (int k = 0; k < 150; k++) begin
                logic [3:0] m;
                m = ($urandom % 3 == 0) ? 4'($urandom) : 4'd0;
                set_in(1'b1, ($urandom % 97 == 0), 4'($urandom), m,
                       4'($urandom), 12'($urandom));
                step("");
            end
            for (int k = 0; k < 80; k++) begin
                set_in(($urandom % 10 == 0), 1'b0, 4'($urandom), 4'($urandom),
                       4'($urandom), 12'($urandom));
                step("");
            end
        end
        finish_run();
    end

endmodule